// File: doc/BRIEF.md
# Timed Serial Register Writer with Integrate Gate

This block is the master side of a link to a peripheral that is programmed by write-only serial frames and then switched between integrating and holding by a single strobe. Register commands arrive one byte at a time on a valid/ready port. Each accepted byte is sent as one frame on a chip-select, clock and data line triple. Every minimum delay the peripheral needs is met by cycle counters. These delays cover chip-select to clock, clock high and low widths, data setup and hold, last edge to chip-select release, and the gap between frames. Each one is given in nanoseconds and rounded up to whole system-clock cycles when the design is elaborated.

A pair of request pulses drives the integrate strobe. A start request raises the strobe only once chip-select has been released for long enough. A request that arrives too early waits until the delay has run out. Two status outputs report when the peripheral can be taken to be integrating, or settled in hold, once its response time has passed after each strobe edge. An optional receive path shifts in the peripheral's data-out line on every falling clock edge and presents each complete byte with a one-cycle pulse.

Top module: `spi_gated_writer`

## Requirements
- R1: Each accepted `cmd_data` byte is sent as exactly FRAME_BITS bits while `cs_n` is low, bit 7 first and bit 0 last. `si` changes only on a rising `sck` edge and holds its value for the whole high phase, so the value present at each falling edge is the bit being sent.
- R2: While `cs_n` is high, `sck` is low and `si` is low.
- R3: From the falling edge of `cs_n`, at least 10 ns pass before the first rising `sck` edge and at least 80 ns before the first falling `sck` edge. At defaults this is 2 and 8 cycles.
- R4: Every `sck` high phase lasts at least 60 ns, which also covers the 20 ns data setup. Every low phase inside a frame lasts at least 60 ns, which also covers the 10 ns data hold. At defaults each phase is 6 cycles.
- R5: At least 80 ns (8 cycles) pass from the final falling `sck` edge of a frame to the rising edge of `cs_n`.
- R6: `cs_n` stays high for at least 200 ns (20 cycles) between two frames.
- R7: `cmd_ready` is high only when no frame or gap is in progress. `busy` is high from the `cs_n` fall until the gap has expired. A byte is taken only on a cycle with both `cmd_valid` and `cmd_ready` high, and one frame is sent per byte taken.
- R8: `int_hold` rises only while `cs_n` is high, and only after `cs_n` has been high for at least 8 us (800 cycles). The delay counts as met out of reset. An `int_start` pulse that arrives before the delay is met is held and acted on at most one cycle after the delay is met. When the delay is already met, `int_hold` rises at the clock edge that samples `int_start`.
- R9: `int_stop` drops `int_hold` at the edge that samples it, and it discards a waiting start request. If both pulses arrive in the same cycle, the stop wins.
- R10: `integ_valid` rises exactly INT_SETTLE + 1 cycles after `int_hold` rises, where INT_SETTLE is 2000 at defaults. It is low in every cycle in which `int_hold` is low.
- R11: `hold_valid` rises exactly HOLD_SETTLE + 1 cycles after `int_hold` falls, where HOLD_SETTLE is 2000 at defaults. It is low in every cycle in which `int_hold` is high. It is high out of reset.
- R12: When capture is enabled, `so` is sampled at each falling `sck` edge. After the final falling edge, `rx_done` pulses high for exactly one cycle with `rx_data` holding the bits received, the first one in bit 7.
- R13: In reset, `cs_n`=1, `sck`=0, `si`=0, `busy`=0, `cmd_ready`=1, `int_hold`=0, `integ_valid`=0, `hold_valid`=1 and `rx_done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command byte offered |
| cmd_data | input | FRAME_BITS | Command byte, sent MSB first |
| cmd_ready | output | 1 | Controller can take a byte this cycle |
| busy | output | 1 | Frame or inter-frame gap in progress |
| int_start | input | 1 | Request to raise the integrate strobe |
| int_stop | input | 1 | Request to lower the integrate strobe |
| cs_n | output | 1 | Active-low chip select |
| sck | output | 1 | Serial clock, idles low |
| si | output | 1 | Serial data to the peripheral |
| so | input | 1 | Serial data from the peripheral |
| int_hold | output | 1 | Integrate (high) / hold (low) strobe |
| integ_valid | output | 1 | Peripheral has had time to start integrating |
| hold_valid | output | 1 | Peripheral has had time to settle in hold |
| rx_data | output | FRAME_BITS | Last byte captured from `so` |
| rx_done | output | 1 | One-cycle pulse when `rx_data` is updated |

## Verification
A phase counter that is off by one shows at the pins within one frame, because the edge-to-edge distances the bench measures on `cs_n` and `sck` come out shorter than the minimum. A stuck bit counter or a wrong shift direction corrupts the next byte that is reconstructed from `si`. The post-release counter and the two settle counters can only be seen thousands of cycles after a strobe edge. For that reason the status rise times are checked for exact cycle counts, and the deferred start is timed from the `cs_n` release to the moment it is acted on.

// File: rtl/spi_gw_pkg.sv
package spi_gw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_HIGH,
      ST_LOW,
      ST_TAIL,
      ST_GAP
   } fr_state_t;

   // nanoseconds to whole clock cycles, rounded up
   function automatic int ns_to_cyc(input int ns, input int per_ns);
      if (ns <= 0) return 0;
      return (ns + per_ns - 1) / per_ns;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/spi_gw_framer.sv
module spi_gw_framer
   import spi_gw_pkg::*;
#(
   parameter int DW         = 8,
   parameter int N_LEAD     = 2,
   parameter int N_HIGH     = 6,
   parameter int N_LOW      = 6,
   parameter int N_TAIL     = 8,
   parameter int N_GAP      = 20,
   parameter int CAPTURE_EN = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   input  logic [DW-1:0] cmd_data,
   output logic          cmd_ready,
   output logic          busy,
   output logic          cs_n,
   output logic          sck,
   output logic          si,
   input  logic          so,
   output logic [DW-1:0] rx_data,
   output logic          rx_done
);

   localparam int NMAX = imax(imax(imax(N_LEAD, N_HIGH), imax(N_LOW, N_TAIL)), N_GAP);
   localparam int CW   = $clog2(NMAX + 1);
   localparam int BW   = $clog2(DW);
   localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

   fr_state_t     st;
   logic [CW-1:0] cnt;
   logic [BW-1:0] bitn;
   logic [DW-1:0] shreg;
   logic          tick;
   logic          fall_stb;
   logic          last_fall;

   assign tick      = (cnt == '0);
   assign cmd_ready = (st == ST_IDLE);
   assign busy      = (st != ST_IDLE);
   assign fall_stb  = (st == ST_HIGH) && tick;
   assign last_fall = fall_stb && (bitn == LAST_BIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         cnt   <= '0;
         bitn  <= '0;
         shreg <= '0;
         cs_n  <= 1'b1;
         sck   <= 1'b0;
         si    <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (cmd_valid) begin
                  shreg <= cmd_data;
                  cs_n  <= 1'b0;
                  cnt   <= CW'(N_LEAD - 1);
                  st    <= ST_LEAD;
               end
            end
            ST_LEAD: begin
               if (tick) begin
                  sck   <= 1'b1;
                  si    <= shreg[DW-1];
                  shreg <= {shreg[DW-2:0], 1'b0};
                  bitn  <= '0;
                  cnt   <= CW'(N_HIGH - 1);
                  st    <= ST_HIGH;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_HIGH: begin
               if (tick) begin
                  sck <= 1'b0;
                  if (bitn == LAST_BIT) begin
                     cnt <= CW'(N_TAIL - 1);
                     st  <= ST_TAIL;
                  end else begin
                     cnt <= CW'(N_LOW - 1);
                     st  <= ST_LOW;
                  end
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_LOW: begin
               if (tick) begin
                  sck   <= 1'b1;
                  si    <= shreg[DW-1];
                  shreg <= {shreg[DW-2:0], 1'b0};
                  bitn  <= bitn + 1'b1;
                  cnt   <= CW'(N_HIGH - 1);
                  st    <= ST_HIGH;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_TAIL: begin
               if (tick) begin
                  cs_n <= 1'b1;
                  si   <= 1'b0;
                  cnt  <= CW'(N_GAP - 1);
                  st   <= ST_GAP;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_GAP: begin
               if (tick) begin
                  st <= ST_IDLE;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   generate
      if (CAPTURE_EN != 0) begin : g_cap
         logic [DW-2:0] rx_sh;
         logic [DW-1:0] rx_next;
         assign rx_next = {rx_sh, so};
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rx_sh   <= '0;
               rx_data <= '0;
               rx_done <= 1'b0;
            end else begin
               rx_done <= 1'b0;
               if (fall_stb) begin
                  rx_sh <= rx_next[DW-2:0];
                  if (last_fall) begin
                     rx_data <= rx_next;
                     rx_done <= 1'b1;
                  end
               end
            end
         end
      end else begin : g_nocap
         assign rx_data = '0;
         assign rx_done = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/spi_gw_intgate.sv
module spi_gw_intgate #(
   parameter int N_INT = 800
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic int_start,
   input  logic int_stop,
   output logic int_hold
);

   localparam int CW = $clog2(N_INT + 1);
   localparam logic [CW-1:0] SAT = CW'(N_INT);

   logic [CW-1:0] since_cs;
   logic          pend;
   logic          allowed;

   assign allowed = cs_n && (since_cs == SAT);

   // cycles since chip select was released, saturating; met out of reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               since_cs <= SAT;
      else if (!cs_n)           since_cs <= '0;
      else if (since_cs != SAT) since_cs <= since_cs + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_hold <= 1'b0;
         pend     <= 1'b0;
      end else if (int_stop) begin
         int_hold <= 1'b0;
         pend     <= 1'b0;
      end else if (int_hold) begin
         pend <= 1'b0;
      end else if (int_start || pend) begin
         if (allowed) begin
            int_hold <= 1'b1;
            pend     <= 1'b0;
         end else begin
            pend <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/spi_gw_settle.sv
module spi_gw_settle
   import spi_gw_pkg::*;
#(
   parameter int N_RISE = 2000,
   parameter int N_FALL = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic rise_ok,
   output logic fall_ok
);

   localparam int NMAX = imax(N_RISE, N_FALL);
   localparam int CW   = $clog2(NMAX + 1);
   localparam logic [CW-1:0] SAT    = CW'(NMAX);
   localparam logic [CW-1:0] RISE_N = CW'(N_RISE);
   localparam logic [CW-1:0] FALL_N = CW'(N_FALL);

   logic          lvl_q;
   logic [CW-1:0] age;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= 1'b0;
         age   <= SAT;
      end else if (lvl != lvl_q) begin
         lvl_q <= lvl;
         age   <= '0;
      end else if (age != SAT) begin
         age <= age + 1'b1;
      end
   end

   assign rise_ok = lvl && lvl_q && (age >= RISE_N);
   assign fall_ok = !lvl && !lvl_q && (age >= FALL_N);

endmodule

// File: rtl/spi_gated_writer.sv
module spi_gated_writer
   import spi_gw_pkg::*;
#(
   parameter int CLK_PERIOD_NS  = 10,
   parameter int FRAME_BITS     = 8,
   parameter int CS_TO_RISE_NS  = 10,
   parameter int CS_TO_FALL_NS  = 80,
   parameter int SCK_HIGH_NS    = 60,
   parameter int SCK_LOW_NS     = 60,
   parameter int SETUP_NS       = 20,
   parameter int HOLD_NS        = 10,
   parameter int LAST_TO_CS_NS  = 80,
   parameter int FRAME_GAP_NS   = 200,
   parameter int CS_TO_INT_NS   = 8000,
   parameter int INT_SETTLE_NS  = 20000,
   parameter int HOLD_SETTLE_NS = 20000,
   parameter int CAPTURE_EN     = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmd_valid,
   input  logic [FRAME_BITS-1:0] cmd_data,
   output logic                  cmd_ready,
   output logic                  busy,
   input  logic                  int_start,
   input  logic                  int_stop,
   output logic                  cs_n,
   output logic                  sck,
   output logic                  si,
   input  logic                  so,
   output logic                  int_hold,
   output logic                  integ_valid,
   output logic                  hold_valid,
   output logic [FRAME_BITS-1:0] rx_data,
   output logic                  rx_done
);

   // setup is covered by the high phase, hold by the low phase
   localparam int N_HIGH = imax(1, imax(ns_to_cyc(SCK_HIGH_NS, CLK_PERIOD_NS),
                                        ns_to_cyc(SETUP_NS, CLK_PERIOD_NS)));
   localparam int N_LOW  = imax(1, imax(ns_to_cyc(SCK_LOW_NS, CLK_PERIOD_NS),
                                        ns_to_cyc(HOLD_NS, CLK_PERIOD_NS)));
   localparam int N_LEAD = imax(1, imax(ns_to_cyc(CS_TO_RISE_NS, CLK_PERIOD_NS),
                                        ns_to_cyc(CS_TO_FALL_NS, CLK_PERIOD_NS) - N_HIGH));
   localparam int N_TAIL = imax(1, ns_to_cyc(LAST_TO_CS_NS, CLK_PERIOD_NS));
   localparam int N_GAP  = imax(1, ns_to_cyc(FRAME_GAP_NS, CLK_PERIOD_NS));
   localparam int N_INT  = imax(1, ns_to_cyc(CS_TO_INT_NS, CLK_PERIOD_NS));
   localparam int N_ISET = imax(1, ns_to_cyc(INT_SETTLE_NS, CLK_PERIOD_NS));
   localparam int N_HSET = imax(1, ns_to_cyc(HOLD_SETTLE_NS, CLK_PERIOD_NS));

   generate
      if (CLK_PERIOD_NS < 1) begin : g_bad_period
         $error("CLK_PERIOD_NS must be positive");
      end
      if (FRAME_BITS < 2) begin : g_bad_width
         $error("FRAME_BITS must be at least 2");
      end
      if (CAPTURE_EN != 0 && CAPTURE_EN != 1) begin : g_bad_cap
         $error("CAPTURE_EN must be 0 or 1");
      end
   endgenerate

   spi_gw_framer #(
      .DW         (FRAME_BITS),
      .N_LEAD     (N_LEAD),
      .N_HIGH     (N_HIGH),
      .N_LOW      (N_LOW),
      .N_TAIL     (N_TAIL),
      .N_GAP      (N_GAP),
      .CAPTURE_EN (CAPTURE_EN)
   ) u_framer (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_data  (cmd_data),
      .cmd_ready (cmd_ready),
      .busy      (busy),
      .cs_n      (cs_n),
      .sck       (sck),
      .si        (si),
      .so        (so),
      .rx_data   (rx_data),
      .rx_done   (rx_done)
   );

   spi_gw_intgate #(
      .N_INT (N_INT)
   ) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n      (cs_n),
      .int_start (int_start),
      .int_stop  (int_stop),
      .int_hold  (int_hold)
   );

   spi_gw_settle #(
      .N_RISE (N_ISET),
      .N_FALL (N_HSET)
   ) u_settle (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl     (int_hold),
      .rise_ok (integ_valid),
      .fall_ok (hold_valid)
   );

endmodule

// File: rtl/spi_gated_writer_chk.sv
module spi_gated_writer_chk #(
   parameter int N_HIGH = 6,
   parameter int N_LOW  = 6,
   parameter int N_INT  = 800
) (
   input logic clk,
   input logic rst_n,
   input logic cs_n,
   input logic sck,
   input logic si,
   input logic busy,
   input logic cmd_ready,
   input logic int_hold,
   input logic integ_valid,
   input logic hold_valid,
   input logic rx_done
);

   localparam int CAP = 1 << 24;

   int  hi_cnt;
   int  lo_cnt;
   int  csh_cnt;
   logic seen_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt    <= 0;
         lo_cnt    <= 0;
         csh_cnt   <= N_INT;
         seen_fall <= 1'b0;
      end else begin
         hi_cnt  <= sck ? ((hi_cnt < CAP) ? hi_cnt + 1 : hi_cnt) : 0;
         lo_cnt  <= (!sck && !cs_n) ? ((lo_cnt < CAP) ? lo_cnt + 1 : lo_cnt) : 0;
         csh_cnt <= cs_n ? ((csh_cnt < N_INT) ? csh_cnt + 1 : csh_cnt) : 0;
         if (cs_n)                     seen_fall <= 1'b0;
         else if (!sck && hi_cnt != 0) seen_fall <= 1'b1;
      end
   end

   // R2: clock and data idle low outside a frame
   p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> (!sck && !si));

   // R1: data only moves on a rising clock edge
   p_si_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck)) |-> $stable(si));

   // R4: minimum high width
   p_high_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sck) |-> (hi_cnt >= N_HIGH));

   // R4: minimum low width between bits
   p_low_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sck) && seen_fall) |-> (lo_cnt >= N_LOW));

   // R7: busy covers the whole frame, ready only when idle
   p_busy_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> busy);
   p_ready_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> !busy);

   // R8: strobe rises only after the release delay
   p_int_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_hold) |-> (cs_n && csh_cnt >= N_INT));

   // R10 / R11: status follows the strobe level
   p_integ_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      integ_valid |-> int_hold);
   p_hold_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
      hold_valid |-> !int_hold);

   // R12: completion pulse lasts one cycle
   p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> !rx_done);

endmodule

bind spi_gated_writer spi_gated_writer_chk #(
   .N_HIGH (N_HIGH),
   .N_LOW  (N_LOW),
   .N_INT  (N_INT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cs_n        (cs_n),
   .sck         (sck),
   .si          (si),
   .busy        (busy),
   .cmd_ready   (cmd_ready),
   .int_hold    (int_hold),
   .integ_valid (integ_valid),
   .hold_valid  (hold_valid),
   .rx_done     (rx_done)
);

// File: tb/spi_gated_writer_tb_top.sv
`timescale 1ns/1ps
module spi_gated_writer_tb_top;

   function automatic int cdiv(input int ns);
      return (ns + 9) / 10;
   endfunction

   localparam int E_LEAD_R = cdiv(10);
   localparam int E_LEAD_F = cdiv(80);
   localparam int E_HIGH   = cdiv(60);
   localparam int E_LOW    = cdiv(60);
   localparam int E_TAIL   = cdiv(80);
   localparam int E_GAP    = cdiv(200);
   localparam int E_INT    = cdiv(8000);
   localparam int E_IS     = cdiv(20000);
   localparam int E_HS     = cdiv(20000);
   localparam int WATCHDOG = 200000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [7:0] cmd_data = '0;
   logic       int_start = 1'b0;
   logic       int_stop = 1'b0;
   logic       so = 1'b0;
   logic       cmd_ready, busy, cs_n, sck, si;
   logic       int_hold, integ_valid, hold_valid, rx_done;
   logic [7:0] rx_data;

   int n_chk = 0;
   int n_fail = 0;
   int n_sent = 0;
   int n_frames = 0;
   logic [7:0] expq[$];

   always #5 clk = ~clk;

   spi_gated_writer dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_valid   (cmd_valid),
      .cmd_data    (cmd_data),
      .cmd_ready   (cmd_ready),
      .busy        (busy),
      .int_start   (int_start),
      .int_stop    (int_stop),
      .cs_n        (cs_n),
      .sck         (sck),
      .si          (si),
      .so          (so),
      .int_hold    (int_hold),
      .integ_valid (integ_valid),
      .hold_valid  (hold_valid),
      .rx_data     (rx_data),
      .rx_done     (rx_done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_data  = b;
      while (!cmd_ready) @(negedge clk);
      expq.push_back(b);
      n_sent++;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic pulse(input bit start, input bit stop);
      @(negedge clk);
      int_start = start;
      int_stop  = stop;
      @(negedge clk);
      int_start = 1'b0;
      int_stop  = 1'b0;
   endtask

   // port monitor: measures edge distances, rebuilds frames, drives so
   initial begin
      int cyc, t_csf, t_csr, t_rise, t_fall, t_ir, t_if, nbits;
      bit have_csr, first;
      logic p_cs, p_sck, p_si, p_int, p_iv, p_hv, p_done;
      logic [7:0] got, so_byte, ev;
      cyc = 0; t_csf = 0; t_csr = 0; t_rise = 0; t_fall = 0; t_ir = 0; t_if = 0;
      nbits = 0; have_csr = 0; first = 0; got = '0; so_byte = '0;
      wait (rst_n === 1'b1);
      @(negedge clk);
      p_cs = cs_n; p_sck = sck; p_si = si; p_int = int_hold;
      p_iv = integ_valid; p_hv = hold_valid; p_done = rx_done;
      forever begin
         @(negedge clk);
         cyc++;
         if (cs_n && (sck || si))
            chk(0, "R2", "sck/si active while cs_n high", {sck, si}, 0);
         if (!cs_n && !busy) chk(0, "R7", "busy low in frame", busy, 1);
         if (cmd_ready && busy) chk(0, "R7", "ready while busy", cmd_ready, 0);
         if (integ_valid && !int_hold) chk(0, "R10", "integ_valid without strobe", 1, 0);
         if (hold_valid && int_hold) chk(0, "R11", "hold_valid with strobe", 1, 0);
         if (p_cs && !cs_n) begin
            if (have_csr) chk(cyc - t_csr >= E_GAP, "R6", "cs_n high gap", cyc - t_csr, E_GAP);
            t_csf = cyc; nbits = 0; first = 1; got = '0;
            so_byte = 8'($urandom);
         end
         if (!p_sck && sck) begin
            if (first) chk(cyc - t_csf >= E_LEAD_R, "R3", "cs fall to first rise", cyc - t_csf, E_LEAD_R);
            else       chk(cyc - t_fall >= E_LOW, "R4", "sck low width", cyc - t_fall, E_LOW);
            t_rise = cyc;
            so = (nbits < 8) ? so_byte[7 - nbits] : 1'b0;
         end
         if (p_sck && !sck) begin
            chk(cyc - t_rise >= E_HIGH, "R4", "sck high width", cyc - t_rise, E_HIGH);
            if (first) chk(cyc - t_csf >= E_LEAD_F, "R3", "cs fall to first fall", cyc - t_csf, E_LEAD_F);
            first = 0;
            got = {got[6:0], p_si};
            nbits++;
            t_fall = cyc;
         end
         if (rx_done) begin
            chk(rx_data == so_byte, "R12", "captured byte", rx_data, so_byte);
            chk(!p_done, "R12", "rx_done single cycle", p_done, 0);
         end
         if (!p_cs && cs_n) begin
            chk(cyc - t_fall >= E_TAIL, "R5", "last fall to cs rise", cyc - t_fall, E_TAIL);
            chk(nbits == 8, "R1", "bits in frame", nbits, 8);
            ev = (expq.size() > 0) ? expq.pop_front() : 8'hxx;
            chk(got === ev, "R1", "frame byte", got, ev);
            n_frames++;
            t_csr = cyc; have_csr = 1;
         end
         if (!p_int && int_hold) begin
            chk(cs_n && (!have_csr || cyc - t_csr >= E_INT), "R8", "cs high before strobe",
                have_csr ? cyc - t_csr : E_INT, E_INT);
            t_ir = cyc;
         end
         if (p_int && !int_hold) t_if = cyc;
         if (!p_iv && integ_valid)
            chk(cyc - t_ir == E_IS + 1, "R10", "integ_valid delay", cyc - t_ir, E_IS + 1);
         if (!p_hv && hold_valid)
            chk(cyc - t_if == E_HS + 1, "R11", "hold_valid delay", cyc - t_if, E_HS + 1);
         p_cs = cs_n; p_sck = sck; p_si = si; p_int = int_hold;
         p_iv = integ_valid; p_hv = hold_valid; p_done = rx_done;
      end
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      chk(0, "R7", "watchdog expired, cycles", WATCHDOG, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int seed_use, n;
      seed_use = $urandom(20240611);
      repeat (4) @(negedge clk);
      // R13: reset values
      chk(cs_n == 1'b1, "R13", "cs_n in reset", cs_n, 1);
      chk(sck == 1'b0, "R13", "sck in reset", sck, 0);
      chk(si == 1'b0, "R13", "si in reset", si, 0);
      chk(busy == 1'b0, "R13", "busy in reset", busy, 0);
      chk(cmd_ready == 1'b1, "R13", "cmd_ready in reset", cmd_ready, 1);
      chk(int_hold == 1'b0, "R13", "int_hold in reset", int_hold, 0);
      chk(integ_valid == 1'b0, "R13", "integ_valid in reset", integ_valid, 0);
      chk(hold_valid == 1'b1, "R13", "hold_valid in reset", hold_valid, 1);
      chk(rx_done == 1'b0, "R13", "rx_done in reset", rx_done, 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(hold_valid == 1'b1, "R11", "hold_valid after reset", hold_valid, 1);

      // R8: delay met out of reset, strobe rises at once
      pulse(1, 0);
      chk(int_hold == 1'b1, "R8", "immediate rise", int_hold, 1);
      chk(hold_valid == 1'b0, "R11", "hold_valid drops with strobe", hold_valid, 0);
      repeat (E_IS + 3) @(negedge clk);
      chk(integ_valid == 1'b1, "R10", "integ_valid after settle", integ_valid, 1);
      // R9: stop lowers the strobe
      pulse(0, 1);
      chk(int_hold == 1'b0, "R9", "stop lowers strobe", int_hold, 0);
      chk(integ_valid == 1'b0, "R10", "integ_valid drops with strobe", integ_valid, 0);
      repeat (E_HS + 3) @(negedge clk);
      chk(hold_valid == 1'b1, "R11", "hold_valid after settle", hold_valid, 1);
      // R9: stop beats start in the same cycle
      pulse(1, 1);
      chk(int_hold == 1'b0, "R9", "stop wins same cycle", int_hold, 0);
      repeat (3) @(negedge clk);
      chk(int_hold == 1'b0, "R9", "no leftover request", int_hold, 0);

      // R1: directed patterns, back to back (R6 gap)
      send(8'h00); send(8'hFF); send(8'hA5); send(8'h80); send(8'h01);

      // R7: byte offered while busy is not taken early
      send(8'h3C);
      @(negedge clk);
      chk(busy == 1'b1, "R7", "busy during frame", busy, 1);
      chk(cmd_ready == 1'b0, "R7", "ready low during frame", cmd_ready, 0);

      // R8: request during a frame waits for the release delay
      pulse(1, 0);
      chk(int_hold == 1'b0, "R8", "deferred while cs low", int_hold, 0);
      while (cs_n == 1'b0) @(negedge clk);
      n = 0;
      while (!int_hold && n < E_INT + 10) begin
         @(negedge clk);
         n++;
      end
      chk(n >= E_INT && n <= E_INT + 1, "R8", "deferred rise delay", n, E_INT + 1);
      send(8'h96);
      pulse(0, 1);
      chk(int_hold == 1'b0, "R9", "stop after deferred rise", int_hold, 0);

      // random traffic
      for (int i = 0; i < 40; i++) begin
         repeat ($urandom % 4) @(negedge clk);
         send(8'($urandom));
      end
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(n_frames == n_sent, "R7", "one frame per accepted byte", n_frames, n_sent);
      chk(expq.size() == 0, "R1", "all bytes sent", expq.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule